// File: doc/BRIEF.md
# Partial Row Merge Unit

This unit assembles one finished row of a sparse product from up to four partial rows. Each partial row is already sorted by ascending column index and sits in memory as a run of consecutive words. A job gives, for each partial row, a base address and a length. The unit reads every entry of the job through a request/response memory port into one bank of a two-bank local store. It then merges the lists by always taking the smallest head column. Entries that share a column are added together, so the row leaves on a stream port strictly ascending and with no duplicate columns. A last flag marks the final entry of each row.

Two engines run side by side on separate banks. The fetch engine fills one bank for job N+1 while the sort engine drains the other bank for job N. The banks change roles only when the fetch engine has received every response of its job and the sort engine has emitted the last entry of its row.

Fetch engine states and transitions:
- F_IDLE goes to F_RUN when a job is accepted.
- F_RUN goes to F_WAIT when every response has arrived.
- F_WAIT goes to F_IDLE on a bank swap.

Sort engine states and transitions:
- S_IDLE goes to S_RUN on a bank swap.
- S_RUN goes to S_IDLE after the entry flagged last is accepted, or at once when the job held no entries.

Top module: `prm_merge_unit`

## Requirements
- R1: During reset and in the cycle after it, `job_ready` is 1, and `req_valid` and `out_valid` are 0.
- R2: Within one row, accepted `out_col` values rise strictly. `out_last` is 1 on the final entry of the row and 0 on every other entry.
- R3: All entries of a job that carry the same column leave as a single output entry. Its value is their sum modulo 2^VALW. Memory words are laid out as {column in the upper COLW bits, value in the lower VALW bits}.
- R4: An entry whose sum is exactly zero is still emitted, with value 0.
- R5: The number of reads issued but not yet answered never exceeds MAX_OUT. Responses arrive in request order.
- R6: Reads are issued list by list, starting with list 0, at base+0, base+1 and so on. A list of length zero issues no read.
- R7: A new job is accepted, and its reads are issued, while the previous row is still waiting at the output. Banks swap only when both engines have finished.
- R8: Rows leave in the order their jobs were accepted.
- R9: A job whose lengths are all zero produces no output entry. The job that follows it is merged correctly.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_col`, `out_val` and `out_last` hold their values.
- R11: A job with a single non-empty list reproduces that list unchanged.
- R12: Each list length is at most LDEPTH. A list of exactly LDEPTH entries is merged in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job descriptor offered |
| job_ready | output | 1 | Fetch engine can accept a job |
| job_base | input | NLIST*AW | Base address of each list, list 0 in the low bits |
| job_len | input | NLIST*LENW | Entry count of each list, list 0 in the low bits |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Word address of the read |
| rsp_valid | input | 1 | Read data valid, in request order |
| rsp_data | input | COLW+VALW | Returned word {column, value} |
| out_valid | output | 1 | Merged entry valid |
| out_ready | input | 1 | Consumer accepts the entry |
| out_col | output | COLW | Column index of the entry |
| out_val | output | VALW | Summed value of the entry |
| out_last | output | 1 | Final entry of the row |

## Verification
A read request becomes visible in the cycle after its job is accepted. A response is stored at the edge that carries it. Merged entries appear once the bank has swapped, and each later entry can follow one cycle after the previous handshake. Because the delay until the first entry depends on memory latency and stalls, the bench records every handshake it sees one time unit after the falling edge. It then compares the recorded stream, entry by entry, with a merge it computes from the memory contents. The hold check for stalls is cycle-exact: whenever an entry is offered without being taken, the next falling edge must show the same entry.

// File: rtl/prm_pkg.sv
`timescale 1ns/1ps
package prm_pkg;

    typedef enum logic [1:0] {
        F_IDLE,
        F_RUN,
        F_WAIT
    } fetch_state_e;

    typedef enum logic {
        S_IDLE,
        S_RUN
    } sort_state_e;

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prm_fetch.sv
`timescale 1ns/1ps
module prm_fetch
    import prm_pkg::*;
#(
    parameter int NLIST   = 4,
    parameter int LDEPTH  = 16,
    parameter int AW      = 16,
    parameter int DW      = 32,
    parameter int MAX_OUT = 64,
    parameter int LENW    = $clog2(LDEPTH + 1),
    parameter int LSTW    = width_of(NLIST),
    parameter int IDXW    = width_of(LDEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  job_valid,
    output logic                  job_ready,
    input  logic [NLIST*AW-1:0]   job_base,
    input  logic [NLIST*LENW-1:0] job_len,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [AW-1:0]         req_addr,
    input  logic                  rsp_valid,
    input  logic [DW-1:0]         rsp_data,
    output logic                  wr_en,
    output logic [LSTW-1:0]       wr_list,
    output logic [IDXW-1:0]       wr_idx,
    output logic [DW-1:0]         wr_data,
    output logic                  fetch_done,
    input  logic                  swap,
    output logic [NLIST*LENW-1:0] lens_out
);

    localparam int CNTW = $clog2(NLIST * LDEPTH + 1);
    localparam int POSW = LSTW + IDXW;

    fetch_state_e state, state_nx;

    logic [AW-1:0]         base_r [NLIST];
    logic [NLIST*LENW-1:0] lens_r;
    logic [CNTW-1:0]       total_r, req_cnt, rsp_cnt, job_total, outst;
    logic [POSW-1:0]       rq_pos, rs_pos;
    logic                  req_fire, rsp_take;

    // First non-empty list whose index is at least 'from'.
    function automatic logic [POSW-1:0] seek(input logic [NLIST*LENW-1:0] lens, input int from);
        logic [POSW-1:0] p;
        logic            hit;
        p   = '0;
        hit = 1'b0;
        for (int k = 0; k < NLIST; k++) begin
            if (!hit && k >= from && lens[k*LENW +: LENW] != '0) begin
                p   = {LSTW'(k), IDXW'(0)};
                hit = 1'b1;
            end
        end
        return p;
    endfunction

    // Position after 'pos' in list-major order.
    function automatic logic [POSW-1:0] step(input logic [NLIST*LENW-1:0] lens, input logic [POSW-1:0] pos);
        logic [LSTW-1:0] l;
        logic [IDXW-1:0] i;
        l = pos[POSW-1:IDXW];
        i = pos[IDXW-1:0];
        if (LENW'(i) + LENW'(1) < lens[int'(l)*LENW +: LENW])
            return {l, i + IDXW'(1)};
        return seek(lens, int'(l) + 1);
    endfunction

    always_comb begin
        job_total = '0;
        for (int k = 0; k < NLIST; k++)
            job_total = job_total + CNTW'(job_len[k*LENW +: LENW]);
    end

    assign outst    = req_cnt - rsp_cnt;
    assign req_fire = req_valid && req_ready;
    assign rsp_take = (state == F_RUN) && rsp_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            F_IDLE: if (job_valid)          state_nx = F_RUN;
            F_RUN:  if (rsp_cnt == total_r) state_nx = F_WAIT;
            F_WAIT: if (swap)               state_nx = F_IDLE;
            default:                        state_nx = F_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lens_r  <= '0;
            total_r <= '0;
            req_cnt <= '0;
            rsp_cnt <= '0;
            rq_pos  <= '0;
            rs_pos  <= '0;
            for (int k = 0; k < NLIST; k++) base_r[k] <= '0;
        end else if (state == F_IDLE && job_valid) begin
            lens_r  <= job_len;
            total_r <= job_total;
            req_cnt <= '0;
            rsp_cnt <= '0;
            rq_pos  <= seek(job_len, 0);
            rs_pos  <= seek(job_len, 0);
            for (int k = 0; k < NLIST; k++) base_r[k] <= job_base[k*AW +: AW];
        end else begin
            if (req_fire) begin
                req_cnt <= req_cnt + CNTW'(1);
                rq_pos  <= step(lens_r, rq_pos);
            end
            if (rsp_take) begin
                rsp_cnt <= rsp_cnt + CNTW'(1);
                rs_pos  <= step(lens_r, rs_pos);
            end
        end
    end

    // outputs
    always_comb begin
        job_ready  = (state == F_IDLE);
        fetch_done = (state == F_WAIT);
        req_valid  = (state == F_RUN) && (req_cnt < total_r) && (int'(outst) < MAX_OUT);
        req_addr   = base_r[rq_pos[POSW-1:IDXW]] + AW'(rq_pos[IDXW-1:0]);
        wr_en      = rsp_take;
        wr_list    = rs_pos[POSW-1:IDXW];
        wr_idx     = rs_pos[IDXW-1:0];
        wr_data    = rsp_data;
        lens_out   = lens_r;
    end

    a_r5_outstanding_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outst) <= MAX_OUT);
    a_r5_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state == F_RUN) && (outst != '0));
    a_r6_addr_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> LENW'(rq_pos[IDXW-1:0]) < lens_r[int'(rq_pos[POSW-1:IDXW])*LENW +: LENW]);

endmodule

// File: rtl/prm_buf.sv
`timescale 1ns/1ps
module prm_buf
    import prm_pkg::*;
#(
    parameter int NLIST  = 4,
    parameter int LDEPTH = 16,
    parameter int DW     = 32,
    parameter int LSTW   = width_of(NLIST),
    parameter int IDXW   = width_of(LDEPTH)
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic                  wr_bank,
    input  logic [LSTW-1:0]       wr_list,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic                  rd_bank,
    input  logic [NLIST*IDXW-1:0] rd_idx,
    output logic [NLIST*DW-1:0]   rd_data
);

    logic [DW-1:0] store [2][NLIST][LDEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_bank][wr_list][wr_idx] <= wr_data;
    end

    for (genvar g = 0; g < NLIST; g++) begin : g_head
        assign rd_data[g*DW +: DW] = store[rd_bank][g][rd_idx[g*IDXW +: IDXW]];
    end

endmodule

// File: rtl/prm_sort.sv
`timescale 1ns/1ps
module prm_sort
    import prm_pkg::*;
#(
    parameter int NLIST  = 4,
    parameter int LDEPTH = 16,
    parameter int COLW   = 16,
    parameter int VALW   = 16,
    parameter int DW     = COLW + VALW,
    parameter int LENW   = $clog2(LDEPTH + 1),
    parameter int LSTW   = width_of(NLIST),
    parameter int IDXW   = width_of(LDEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NLIST*LENW-1:0] start_lens,
    output logic                  sort_idle,
    output logic [NLIST*IDXW-1:0] rd_idx,
    input  logic [NLIST*DW-1:0]   rd_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [COLW-1:0]       out_col,
    output logic [VALW-1:0]       out_val,
    output logic                  out_last
);

    sort_state_e state, state_nx;

    logic [NLIST*LENW-1:0] lens_r;
    logic [LENW-1:0]       head [NLIST];
    logic [NLIST-1:0]      live;
    logic                  pend_v;
    logic [COLW-1:0]       pend_col;
    logic [VALW-1:0]       pend_val;
    logic                  any_live;
    logic [LSTW-1:0]       min_l;
    logic [COLW-1:0]       min_col;
    logic [VALW-1:0]       min_val;
    logic                  emit;

    // pick the smallest head column, lowest list on a tie
    always_comb begin
        any_live = 1'b0;
        min_l    = '0;
        min_col  = '0;
        min_val  = '0;
        for (int k = 0; k < NLIST; k++) begin
            live[k] = head[k] < lens_r[k*LENW +: LENW];
            if (live[k] && (!any_live || rd_data[k*DW + VALW +: COLW] < min_col)) begin
                any_live = 1'b1;
                min_l    = LSTW'(k);
                min_col  = rd_data[k*DW + VALW +: COLW];
                min_val  = rd_data[k*DW +: VALW];
            end
        end
    end

    assign emit = (state == S_RUN) && pend_v && (!any_live || min_col != pend_col);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_RUN;
            S_RUN:  if ((!pend_v && !any_live) || (emit && out_ready && !any_live))
                        state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lens_r   <= '0;
            pend_v   <= 1'b0;
            pend_col <= '0;
            pend_val <= '0;
            for (int k = 0; k < NLIST; k++) head[k] <= '0;
        end else if (start) begin
            lens_r <= start_lens;
            pend_v <= 1'b0;
            for (int k = 0; k < NLIST; k++) head[k] <= '0;
        end else if (state == S_RUN) begin
            if (!pend_v) begin
                if (any_live) begin
                    pend_v   <= 1'b1;
                    pend_col <= min_col;
                    pend_val <= min_val;
                    for (int k = 0; k < NLIST; k++)
                        if (LSTW'(k) == min_l) head[k] <= head[k] + LENW'(1);
                end
            end else if (any_live && min_col == pend_col) begin
                pend_val <= pend_val + min_val;
                for (int k = 0; k < NLIST; k++)
                    if (LSTW'(k) == min_l) head[k] <= head[k] + LENW'(1);
            end else if (out_ready) begin
                if (any_live) begin
                    pend_col <= min_col;
                    pend_val <= min_val;
                    for (int k = 0; k < NLIST; k++)
                        if (LSTW'(k) == min_l) head[k] <= head[k] + LENW'(1);
                end else begin
                    pend_v <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sort_idle = (state == S_IDLE);
        out_valid = emit;
        out_col   = pend_col;
        out_val   = pend_val;
        out_last  = !any_live;
        for (int k = 0; k < NLIST; k++) rd_idx[k*IDXW +: IDXW] = head[k][IDXW-1:0];
    end

    // checker state: previous accepted column within the row
    logic            have_prev;
    logic [COLW-1:0] prev_col;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_col  <= '0;
        end else if (out_valid && out_ready) begin
            have_prev <= !out_last;
            prev_col  <= out_col;
        end
    end

    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && have_prev) |-> (out_col > prev_col));
    a_r2_last_closes_row: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_col) && $stable(out_val) && $stable(out_last));

endmodule

// File: rtl/prm_merge_unit.sv
`timescale 1ns/1ps
module prm_merge_unit
    import prm_pkg::*;
#(
    parameter int NLIST   = 4,
    parameter int LDEPTH  = 16,
    parameter int AW      = 16,
    parameter int COLW    = 16,
    parameter int VALW    = 16,
    parameter int MAX_OUT = 64,
    parameter int LENW    = $clog2(LDEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  job_valid,
    output logic                  job_ready,
    input  logic [NLIST*AW-1:0]   job_base,
    input  logic [NLIST*LENW-1:0] job_len,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [AW-1:0]         req_addr,
    input  logic                  rsp_valid,
    input  logic [COLW+VALW-1:0]  rsp_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [COLW-1:0]       out_col,
    output logic [VALW-1:0]       out_val,
    output logic                  out_last
);

    localparam int DW   = COLW + VALW;
    localparam int LSTW = width_of(NLIST);
    localparam int IDXW = width_of(LDEPTH);

    logic                  wr_en, fetch_done, sort_idle, swap, fill_bank;
    logic [LSTW-1:0]       wr_list;
    logic [IDXW-1:0]       wr_idx;
    logic [DW-1:0]         wr_data;
    logic [NLIST*LENW-1:0] fetched_lens;
    logic [NLIST*IDXW-1:0] rd_idx;
    logic [NLIST*DW-1:0]   rd_data;

    assign swap = fetch_done && sort_idle;

    always_ff @(posedge clk) begin
        if (!rst_n)    fill_bank <= 1'b0;
        else if (swap) fill_bank <= !fill_bank;
    end

    prm_fetch #(
        .NLIST(NLIST), .LDEPTH(LDEPTH), .AW(AW), .DW(DW),
        .MAX_OUT(MAX_OUT), .LENW(LENW), .LSTW(LSTW), .IDXW(IDXW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .job_valid(job_valid), .job_ready(job_ready),
        .job_base(job_base), .job_len(job_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wr_en(wr_en), .wr_list(wr_list), .wr_idx(wr_idx), .wr_data(wr_data),
        .fetch_done(fetch_done), .swap(swap), .lens_out(fetched_lens)
    );

    prm_buf #(
        .NLIST(NLIST), .LDEPTH(LDEPTH), .DW(DW), .LSTW(LSTW), .IDXW(IDXW)
    ) u_buf (
        .clk(clk),
        .wr_en(wr_en), .wr_bank(fill_bank), .wr_list(wr_list),
        .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_bank(!fill_bank), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    prm_sort #(
        .NLIST(NLIST), .LDEPTH(LDEPTH), .COLW(COLW), .VALW(VALW),
        .DW(DW), .LENW(LENW), .LSTW(LSTW), .IDXW(IDXW)
    ) u_sort (
        .clk(clk), .rst_n(rst_n),
        .start(swap), .start_lens(fetched_lens), .sort_idle(sort_idle),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_col(out_col), .out_val(out_val), .out_last(out_last)
    );

    logic len_bad;
    always_comb begin
        len_bad = 1'b0;
        for (int k = 0; k < NLIST; k++)
            if (int'(job_len[k*LENW +: LENW]) > LDEPTH) len_bad = 1'b1;
    end

    a_r12_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> !len_bad);
    a_r7_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sort_idle) |=> $stable(fill_bank));

endmodule

// File: tb/prm_merge_unit_tb.sv
`timescale 1ns/1ps
module prm_merge_unit_tb;

    localparam int NL   = 4;
    localparam int LD   = 16;
    localparam int AW   = 16;
    localparam int CW   = 16;
    localparam int VW   = 16;
    localparam int MAXO = 4;
    localparam int LENW = $clog2(LD + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 job_valid = 1'b0;
    logic                 job_ready;
    logic [NL*AW-1:0]     job_base = '0;
    logic [NL*LENW-1:0]   job_len = '0;
    logic                 req_valid;
    logic                 req_ready = 1'b0;
    logic [AW-1:0]        req_addr;
    logic                 rsp_valid = 1'b0;
    logic [CW+VW-1:0]     rsp_data = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [CW-1:0]        out_col;
    logic [VW-1:0]        out_val;
    logic                 out_last;

    prm_merge_unit #(
        .NLIST(NL), .LDEPTH(LD), .AW(AW), .COLW(CW), .VALW(VW), .MAX_OUT(MAXO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .job_valid(job_valid), .job_ready(job_ready),
        .job_base(job_base), .job_len(job_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_col(out_col), .out_val(out_val), .out_last(out_last)
    );

    always #10 clk = !clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int or_mode = 1;
    int rr_mode = 1;
    int stall_checks = 0;
    logic hold_rsp = 1'b0;

    logic [31:0] mem [0:1023];
    int jb [NL];
    int jl [NL];

    logic [AW-1:0] q_addr [$];
    int            q_time [$];
    logic [AW-1:0] req_log [$];
    logic [CW-1:0] got_col [$];
    logic [VW-1:0] got_val [$];
    logic          got_last [$];
    logic [CW-1:0] exp_col [$];
    logic [VW-1:0] exp_val [$];
    logic          exp_last [$];
    logic [AW-1:0] exp_addr [$];

    task automatic check(input string req, input logic ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // cycle counter and watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    // memory model: in-order responses, two cycles after acceptance
    initial begin
        forever begin
            @(negedge clk);
            if (!hold_rsp && q_addr.size() > 0 && q_time[0] <= cyc) begin
                rsp_valid = 1'b1;
                rsp_data  = mem[q_addr.pop_front() % 1024];
                void'(q_time.pop_front());
            end else begin
                rsp_valid = 1'b0;
            end
            req_ready = (rr_mode == 1) ? 1'b1 : ((cyc % 2) == 0);
            #1;
            if (req_valid && req_ready && rst_n) begin
                q_addr.push_back(req_addr);
                q_time.push_back(cyc + 2);
                req_log.push_back(req_addr);
            end
        end
    end

    // output collector with stall-hold check
    initial begin
        logic          prev_stall;
        logic [CW-1:0] pc;
        logic [VW-1:0] pv;
        logic          pl;
        prev_stall = 1'b0;
        pc = '0; pv = '0; pl = 1'b0;
        forever begin
            @(negedge clk);
            out_ready = (or_mode == 1) ? 1'b1 : (or_mode == 0) ? 1'b0 : ((cyc % 3) != 0);
            #1;
            if (prev_stall) begin
                stall_checks++;
                check("R10 stalled entry held", out_valid && out_col == pc && out_val == pv && out_last == pl,
                      int'(out_col), int'(pc));
            end
            if (out_valid && out_ready) begin
                got_col.push_back(out_col);
                got_val.push_back(out_val);
                got_last.push_back(out_last);
            end
            prev_stall = out_valid && !out_ready;
            pc = out_col; pv = out_val; pl = out_last;
        end
    end

    task automatic put(input int addr, input int col, input int val);
        mem[addr] = {CW'(col), VW'(val)};
    endtask

    task automatic set_list(input int l, input int base, input int n, input int c0, input int cstep);
        jb[l] = base;
        jl[l] = n;
        for (int i = 0; i < n; i++) put(base + i, c0 + i * cstep, (c0 + i * cstep) * 7 + l + 1);
    endtask

    task automatic clear_job();
        for (int l = 0; l < NL; l++) begin jb[l] = 0; jl[l] = 0; end
    endtask

    task automatic clear_all();
        got_col.delete(); got_val.delete(); got_last.delete();
        exp_col.delete(); exp_val.delete(); exp_last.delete();
        exp_addr.delete(); req_log.delete();
    endtask

    // reference merge of the current job, appended to the expectation
    task automatic build_expected();
        logic [VW-1:0] acc [int];
        int n;
        for (int l = 0; l < NL; l++)
            for (int i = 0; i < jl[l]; i++) begin
                int c;
                c = int'(mem[jb[l] + i][CW+VW-1:VW]);
                if (acc.exists(c)) acc[c] = acc[c] + mem[jb[l] + i][VW-1:0];
                else               acc[c] = mem[jb[l] + i][VW-1:0];
                exp_addr.push_back(AW'(jb[l] + i));
            end
        n = 0;
        foreach (acc[c]) begin
            n++;
            exp_col.push_back(CW'(c));
            exp_val.push_back(acc[c]);
            exp_last.push_back(n == acc.num());
        end
    endtask

    task automatic start_job(output logic took);
        took = 1'b0;
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            job_base[l*AW +: AW]     = AW'(jb[l]);
            job_len[l*LENW +: LENW]  = LENW'(jl[l]);
        end
        job_valid = 1'b1;
        for (int t = 0; t < 400 && !took; t++) begin
            #1;
            if (job_ready) took = 1'b1;
            @(negedge clk);
        end
        job_valid = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_stream(input string req);
        for (int t = 0; t < 3000 && got_col.size() < exp_col.size(); t++) @(negedge clk);
        wait_cycles(6);
        check({req, " entry count"}, got_col.size() == exp_col.size(), got_col.size(), exp_col.size());
        for (int i = 0; i < exp_col.size() && i < got_col.size(); i++) begin
            check({req, " column"}, got_col[i] == exp_col[i], int'(got_col[i]), int'(exp_col[i]));
            check({req, " value"},  got_val[i] == exp_val[i], int'(got_val[i]), int'(exp_val[i]));
            check({req, " R2 last flag"}, got_last[i] == exp_last[i], int'(got_last[i]), int'(exp_last[i]));
        end
    endtask

    task automatic check_addrs(input string req);
        check({req, " read count"}, req_log.size() == exp_addr.size(), req_log.size(), exp_addr.size());
        for (int i = 0; i < exp_addr.size() && i < req_log.size(); i++)
            check({req, " read address"}, req_log[i] == exp_addr[i], int'(req_log[i]), int'(exp_addr[i]));
    endtask

    task automatic t_reset();
        #1;
        check("R1 job_ready in reset", job_ready == 1'b1, int'(job_ready), 1);
        check("R1 req_valid in reset", req_valid == 1'b0, int'(req_valid), 0);
        check("R1 out_valid in reset", out_valid == 1'b0, int'(out_valid), 0);
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 job_ready after reset", job_ready == 1'b1, int'(job_ready), 1);
        check("R1 req_valid after reset", req_valid == 1'b0, int'(req_valid), 0);
        check("R1 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
    endtask

    task automatic t_single();
        logic took;
        clear_all(); clear_job();
        put(0, 2, 11); put(1, 5, 12); put(2, 9, 13);
        put(3, 10, 14); put(4, 20, 15); put(5, 33, 16);
        jb[0] = 0; jl[0] = 6;
        build_expected();
        start_job(took);
        check("R11 job accepted", took, int'(took), 1);
        check_stream("R11 single list");
        check_addrs("R6 single list");
    endtask

    task automatic t_merge();
        logic took;
        clear_all(); clear_job();
        set_list(0, 100, 5, 1, 3);
        set_list(2, 300, 4, 4, 3);
        set_list(3, 400, LD, 0, 2);
        build_expected();
        start_job(took);
        check("R12 full-depth job accepted", took, int'(took), 1);
        check_stream("R3 R12 merge with collisions");
        check_addrs("R6 empty list skipped");
    endtask

    task automatic t_zero_sum();
        logic took;
        logic seen;
        clear_all(); clear_job();
        put(500, 5, 3);      jb[0] = 500; jl[0] = 1;
        put(510, 5, 16'hFFFD); jb[1] = 510; jl[1] = 1;
        put(520, 9, 1);      jb[2] = 520; jl[2] = 1;
        build_expected();
        start_job(took);
        check_stream("R4 zero sum");
        seen = 1'b0;
        for (int i = 0; i < got_col.size(); i++)
            if (got_col[i] == CW'(5) && got_val[i] == '0) seen = 1'b1;
        check("R4 zero entry present", seen, int'(seen), 1);
    endtask

    task automatic t_empty_job();
        logic took;
        clear_all(); clear_job();
        start_job(took);
        wait_cycles(40);
        check("R9 empty job emits nothing", got_col.size() == 0, got_col.size(), 0);
        check("R9 empty job issues no read", req_log.size() == 0, req_log.size(), 0);
        set_list(1, 600, 3, 8, 4);
        build_expected();
        start_job(took);
        check_stream("R9 job after empty job");
    endtask

    task automatic t_outstanding();
        logic took;
        clear_all(); clear_job();
        hold_rsp = 1'b1;
        set_list(0, 700, 10, 0, 1);
        build_expected();
        start_job(took);
        wait_cycles(30);
        check("R5 reads capped while responses held", req_log.size() == MAXO, req_log.size(), MAXO);
        hold_rsp = 1'b0;
        check_stream("R5 row after release");
        check_addrs("R6 capped reads");
    endtask

    task automatic t_overlap();
        logic took;
        clear_all(); clear_job();
        or_mode = 0;
        set_list(0, 800, 3, 10, 1);
        build_expected();
        start_job(took);
        wait_cycles(30);
        check("R7 first row waiting at output", out_valid == 1'b1, int'(out_valid), 1);
        clear_job();
        set_list(1, 900, 4, 1, 2);
        build_expected();
        start_job(took);
        check("R7 second job accepted during stall", took && got_col.size() == 0, int'(took), 1);
        wait_cycles(30);
        check("R7 second job read while first stalled", req_log.size() == 7 && got_col.size() == 0,
              req_log.size(), 7);
        or_mode = 1;
        check_stream("R8 rows in job order");
    endtask

    task automatic t_backpressure();
        logic took;
        clear_all(); clear_job();
        or_mode = 2;
        rr_mode = 2;
        stall_checks = 0;
        set_list(0, 40, 6, 0, 5);
        set_list(1, 50, 6, 3, 4);
        set_list(2, 60, 5, 1, 6);
        set_list(3, 70, 7, 2, 3);
        build_expected();
        start_job(took);
        check_stream("R10 under backpressure");
        check("R10 stalls observed", stall_checks > 0, stall_checks, 1);
        or_mode = 1;
        rr_mode = 1;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        t_reset();
        t_single();
        t_merge();
        t_zero_sum();
        t_empty_job();
        t_outstanding();
        t_overlap();
        t_backpressure();
        wait_cycles(5);
        finish_run();
    end

endmodule